// File: doc/BRIEF.md
# Virtualized ID register access unit

This unit holds a 32-bit shadow copy of the processor identification value. It sits next to a fixed, parameter-supplied hardware ID. It accepts one system-register access per cycle, tagged with:

- a coprocessor/opcode encoding,
- the current privilege level (0 to 3),
- the hypervisor state bits.

It decides whether the access completes or is refused. A refused access is either undefined or trapped to the hypervisor with a syndrome code. For a completed read it returns the selected value.

Kernel-level reads of the hardware ID encoding are redirected to the shadow value whenever the hypervisor is enabled. This lets the hypervisor present a chosen identity to a guest. The shadow value can only be programmed from the hypervisor level, or from the monitor level in non-secure state. Whether a hypervisor level exists is fixed at build time by a parameter.

Responses appear one cycle after the request strobe. Each request raises exactly one of three outputs: completed, undefined or trapped.

Top module: `vid_access_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the shadow register holds REAL_ID and all response outputs are 0.
- R2: The response to a request appears in the cycle after req_valid_i. Exactly one of rsp_valid_o, undef_o or trap_o is 1 in that cycle. All three are 0 after a cycle with no request.
- R3: At privilege level 0, every access to either encoding is undefined.
- R4: At level 1, with hyp_en_i=1 and trap_en_i=1, an access to either encoding traps. trap_o=1, syndrome_o=8'h03, and trap_wide_o equals hyp_wide_i.
- R5: At level 1 without a trap, an access to the shadow encoding is undefined. A read of the ID encoding returns the shadow value when hyp_en_i=1 and REAL_ID otherwise.
- R6: At level 2, a read of the shadow encoding returns the shadow register. A write loads it from wdata_i. A read of the ID encoding returns REAL_ID.
- R7: At level 3 with a hypervisor level present, a shadow access is undefined when non_secure_i=0 and behaves as at level 2 when non_secure_i=1. ID reads return REAL_ID.
- R8: At level 3 without a hypervisor level, a shadow read returns REAL_ID. A shadow write completes with no effect on the shadow register.
- R9: Encodings are matched as follows:
  - Every access must have coproc 15 and crn, crm and opc2 all 0.
  - opc1=4 selects the shadow register.
  - opc1=0 selects the hardware ID.
  - Any other encoding is undefined, and so is any write to the hardware ID encoding.
- R10: A request that ends undefined or trapped leaves the shadow register unchanged. rdata_o is 0 for every response other than a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 for write, 0 for read |
| coproc_i | input | 4 | Coprocessor number |
| opc1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register field |
| crm_i | input | 4 | Secondary register field |
| opc2_i | input | 3 | Second opcode field |
| priv_i | input | 2 | Current privilege level |
| hyp_en_i | input | 1 | Hypervisor level enabled |
| hyp_wide_i | input | 1 | Hypervisor runs in 64-bit register mode |
| trap_en_i | input | 1 | Hypervisor trap control bit |
| non_secure_i | input | 1 | Non-secure state bit |
| wdata_i | input | 32 | Write operand |
| rsp_valid_o | output | 1 | Access completed |
| rdata_o | output | 32 | Read data |
| undef_o | output | 1 | Undefined access |
| trap_o | output | 1 | Trapped to hypervisor |
| trap_wide_o | output | 1 | Trap taken into the 64-bit hypervisor form |
| syndrome_o | output | 8 | Trap syndrome code |

## Verification
Each access is tried with every privilege level and with both encodings. At level 1, the hypervisor enable and trap bits are toggled independently. This separates a trap from an undefined access, and a redirected ID read from a plain one.

At level 3 the non-secure bit is flipped. A second instance without a hypervisor level is stimulated in parallel, which separates the ignored write from a real load. Shadow contents are read back after every refused or ignored write. Malformed encodings check that a near-miss field is never decoded as a hit.

// File: rtl/vid_pkg.sv
package vid_pkg;
  typedef enum logic [1:0] {ENC_NONE, ENC_SHADOW, ENC_REAL} enc_e;
  typedef enum logic [1:0] {ACT_UNDEF, ACT_DATA, ACT_TRAP} act_e;
  typedef enum logic [1:0] {SRC_ZERO, SRC_SHADOW, SRC_REAL} src_e;
  localparam logic [3:0] COPROC_SYS = 4'hF;
  localparam logic [7:0] TRAP_SYN   = 8'h03;
endpackage

// File: rtl/vid_enc_decode.sv
module vid_enc_decode
  import vid_pkg::*;
#(
  parameter logic [2:0] SHADOW_OPC1 = 3'd4,
  parameter logic [2:0] REAL_OPC1   = 3'd0
) (
  input  logic [3:0] coproc_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output enc_e       enc_o
);
  logic base_hit;
  assign base_hit = (coproc_i == COPROC_SYS) && (crn_i == '0) && (crm_i == '0) && (opc2_i == '0);

  always_comb begin
    enc_o = ENC_NONE;
    if (base_hit && opc1_i == SHADOW_OPC1)    enc_o = ENC_SHADOW;
    else if (base_hit && opc1_i == REAL_OPC1) enc_o = ENC_REAL;
  end
endmodule

// File: rtl/vid_access_policy.sv
module vid_access_policy
  import vid_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  enc_e       enc_i,
  input  logic       write_i,
  input  logic [1:0] priv_i,
  input  logic       hyp_en_i,
  input  logic       trap_en_i,
  input  logic       non_secure_i,
  output act_e       act_o,
  output src_e       src_o,
  output logic       wr_en_o
);
  always_comb begin
    act_o   = ACT_UNDEF;
    src_o   = SRC_ZERO;
    wr_en_o = 1'b0;
    if (enc_i != ENC_NONE) begin
      unique case (priv_i)
        2'd0: act_o = ACT_UNDEF;
        2'd1: begin
          if (hyp_en_i && trap_en_i) begin
            act_o = ACT_TRAP;
          end else if (enc_i == ENC_REAL && !write_i) begin
            act_o = ACT_DATA;
            src_o = hyp_en_i ? SRC_SHADOW : SRC_REAL;
          end
        end
        default: begin
          if (enc_i == ENC_REAL) begin
            if (!write_i) begin
              act_o = ACT_DATA;
              src_o = SRC_REAL;
            end
          end else if (priv_i == 2'd3 && !HAS_HYP) begin
            // no hypervisor level: shadow aliases the real ID, writes dropped
            act_o = ACT_DATA;
            src_o = write_i ? SRC_ZERO : SRC_REAL;
          end else if (priv_i == 2'd2 || non_secure_i) begin
            act_o   = ACT_DATA;
            wr_en_o = write_i;
            src_o   = write_i ? SRC_ZERO : SRC_SHADOW;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vid_access_unit.sv
module vid_access_unit
  import vid_pkg::*;
#(
  parameter int            DATA_W  = 32,
  parameter int            SYN_W   = 8,
  parameter logic [31:0]   REAL_ID = 32'h4A1F_C0D3,
  parameter bit            HAS_HYP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [3:0]        coproc_i,
  input  logic [2:0]        opc1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        opc2_i,
  input  logic [1:0]        priv_i,
  input  logic              hyp_en_i,
  input  logic              hyp_wide_i,
  input  logic              trap_en_i,
  input  logic              non_secure_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              undef_o,
  output logic              trap_o,
  output logic              trap_wide_o,
  output logic [SYN_W-1:0]  syndrome_o
);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(REAL_ID);
  localparam logic [SYN_W-1:0]  SYN_VAL   = SYN_W'(TRAP_SYN);

  enc_e              enc;
  act_e              act;
  src_e              src;
  logic              wr_en;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rd_mux;

  vid_enc_decode u_dec (
    .coproc_i(coproc_i), .opc1_i(opc1_i), .crn_i(crn_i),
    .crm_i(crm_i), .opc2_i(opc2_i), .enc_o(enc)
  );

  vid_access_policy #(.HAS_HYP(HAS_HYP)) u_pol (
    .enc_i(enc), .write_i(req_write_i), .priv_i(priv_i),
    .hyp_en_i(hyp_en_i), .trap_en_i(trap_en_i), .non_secure_i(non_secure_i),
    .act_o(act), .src_o(src), .wr_en_o(wr_en)
  );

  always_comb begin
    unique case (src)
      SRC_SHADOW: rd_mux = shadow_q;
      SRC_REAL:   rd_mux = RESET_VAL;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   shadow_q <= RESET_VAL;
    else if (req_valid_i && wr_en) shadow_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      undef_o     <= 1'b0;
      trap_o      <= 1'b0;
      trap_wide_o <= 1'b0;
      syndrome_o  <= '0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && act == ACT_DATA;
      undef_o     <= req_valid_i && act == ACT_UNDEF;
      trap_o      <= req_valid_i && act == ACT_TRAP;
      trap_wide_o <= req_valid_i && act == ACT_TRAP && hyp_wide_i;
      syndrome_o  <= (req_valid_i && act == ACT_TRAP) ? SYN_VAL : '0;
      rdata_o     <= req_valid_i ? rd_mux : '0;
    end
  end

  assert_one_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> $countones({rsp_valid_o, undef_o, trap_o}) == 1);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !undef_o && !trap_o);
  assert_lvl0_undef_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && priv_i == 2'd0 |=> undef_o);
  assert_trap_syn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> syndrome_o == SYN_VAL);
  assert_shadow_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && wr_en |=> shadow_q == $past(wdata_i));
  assert_bad_coproc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && coproc_i != COPROC_SYS |=> undef_o);
  assert_shadow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && wr_en) |=> $stable(shadow_q));
  assert_rdata_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> rdata_o == '0);
endmodule

// File: tb/vid_access_unit_tb.sv
module vid_access_unit_tb;
  localparam logic [31:0] RID = 32'h4A1F_C0D3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [3:0]  coproc = 4'hF, crn = '0, crm = '0;
  logic [2:0]  opc1 = '0, opc2 = '0;
  logic [1:0]  priv = '0;
  logic        hen = 1'b0, hwide = 1'b0, ten = 1'b0, ns = 1'b0;
  logic [31:0] wdata = '0;

  logic        v_a, u_a, t_a, w_a, v_b, u_b, t_b, w_b;
  logic [31:0] d_a, d_b;
  logic [7:0]  s_a, s_b;

  int errors = 0, checks = 0;
  logic [31:0] sh_a = RID, sh_b = RID;

  always #4 clk = ~clk;

  vid_access_unit #(.REAL_ID(RID), .HAS_HYP(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .coproc_i(coproc), .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2),
    .priv_i(priv), .hyp_en_i(hen), .hyp_wide_i(hwide), .trap_en_i(ten),
    .non_secure_i(ns), .wdata_i(wdata),
    .rsp_valid_o(v_a), .rdata_o(d_a), .undef_o(u_a), .trap_o(t_a),
    .trap_wide_o(w_a), .syndrome_o(s_a));

  vid_access_unit #(.REAL_ID(RID), .HAS_HYP(1'b0)) u_dut_nohyp (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .coproc_i(coproc), .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2),
    .priv_i(priv), .hyp_en_i(hen), .hyp_wide_i(hwide), .trap_en_i(ten),
    .non_secure_i(ns), .wdata_i(wdata),
    .rsp_valid_o(v_b), .rdata_o(d_b), .undef_o(u_b), .trap_o(t_b),
    .trap_wide_o(w_b), .syndrome_o(s_b));

  // {load, valid, undef, trap, wide, syn[7:0], rdata[31:0]}
  function automatic logic [44:0] model(bit hyp, logic [31:0] sh);
    bit sys = coproc == 4'hF && crn == 0 && crm == 0 && opc2 == 0;
    bit is_sh = sys && opc1 == 3'd4;
    bit is_id = sys && opc1 == 3'd0;
    logic [44:0] undef_r = {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h0};
    logic [44:0] data_r  = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0};
    if (!is_sh && !is_id) return undef_r;
    if (priv == 0) return undef_r;
    if (priv == 1) begin
      if (hen && ten) return {1'b0, 1'b0, 1'b0, 1'b1, hwide, 8'h03, 32'h0};
      if (is_id && !wr) return {data_r[44:32], hen ? sh : RID};
      return undef_r;
    end
    if (is_id) return wr ? undef_r : {data_r[44:32], RID};
    if (priv == 3 && !hyp) return wr ? data_r : {data_r[44:32], RID};
    if (priv == 3 && !ns) return undef_r;
    if (wr) return {1'b1, data_r[43:0]};
    return {data_r[44:32], sh};
  endfunction

  task automatic cmp(string tag, string inst, logic [43:0] act, logic [43:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, inst, act, exp);
    end
  endtask

  task automatic req(string tag, bit w, logic [1:0] p, logic [2:0] o1, logic [31:0] wd,
                     logic [3:0] cp = 4'hF, logic [3:0] cn = 4'h0, logic [2:0] o2 = 3'h0);
    logic [44:0] ea, eb;
    @(negedge clk);
    valid = 1'b1; wr = w; priv = p; opc1 = o1; wdata = wd;
    coproc = cp; crn = cn; opc2 = o2;
    ea = model(1'b1, sh_a);
    eb = model(1'b0, sh_b);
    @(posedge clk); #1;
    cmp(tag, "hyp", {v_a, u_a, t_a, w_a, s_a, d_a}, ea[43:0]);
    cmp(tag, "nohyp", {v_b, u_b, t_b, w_b, s_b, d_b}, eb[43:0]);
    if (ea[44]) sh_a = wd;
    if (eb[44]) sh_b = wd;
    valid = 1'b0;
    @(posedge clk); #1;
    cmp("R2", "hyp idle", {v_a, u_a, t_a, d_a}, '0);
    cmp("R2", "nohyp idle", {v_b, u_b, t_b, d_b}, '0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "hyp reset", {v_a, u_a, t_a, d_a}, '0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    cmp("R1", "nohyp post-reset", {v_b, u_b, t_b, d_b}, '0);
    req("R1", 0, 2, 4, 0);
    req("R6", 1, 2, 4, 32'h1234_5678);
    req("R6", 0, 2, 4, 0);
    req("R6", 0, 2, 0, 0);
    req("R3", 0, 0, 4, 0);
    req("R3", 1, 0, 4, 32'hDEAD_BEEF);
    req("R3", 0, 0, 0, 0);
    req("R10", 0, 2, 4, 0);
    hen = 1; ten = 1; hwide = 1;
    req("R4", 1, 1, 4, 32'h5555_AAAA);
    hwide = 0;
    req("R4", 0, 1, 0, 0);
    req("R10", 0, 2, 4, 0);
    ten = 0;
    req("R5", 0, 1, 4, 0);
    req("R5", 1, 1, 4, 32'h0BAD_0BAD);
    req("R5", 0, 1, 0, 0);
    hen = 0; ten = 1;
    req("R5", 0, 1, 0, 0);
    ns = 0;
    req("R7", 0, 3, 4, 0);
    req("R7", 1, 3, 4, 32'h7777_7777);
    req("R7", 0, 3, 0, 0);
    ns = 1;
    req("R7", 1, 3, 4, 32'hCAFE_F00D);
    req("R8", 0, 3, 4, 0);
    hen = 1; ten = 0;
    req("R8", 0, 1, 0, 0);
    req("R9", 0, 2, 4, 0, 4'hE);
    req("R9", 0, 2, 2, 0);
    req("R9", 0, 2, 4, 0, 4'hF, 4'h1);
    req("R9", 0, 2, 0, 0, 4'hF, 4'h0, 3'h1);
    req("R9", 1, 2, 0, 32'h1111_2222);
    req("R10", 0, 2, 4, 0);
    req("R10", 0, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule